// File: doc/BRIEF.md
# Prioritized Console Transmit Line Selector

This block is the register front end of a console port that drives four logical output lines through one shared transmit control/status register and one shared transmit data register. Software never names a destination line. It writes a line-enable mask, and the block chooses the highest-priority line that is both enabled and idle. The block reports that choice in an ID field, and the next data write goes to that line.

Each line has a one-cycle valid strobe with a 16-bit data word, and a one-cycle completion input. A line is busy from the data write until its completion pulse. The completion pulse makes the line ready again and triggers a new choice of line. The block also holds a receive control/status and data register pair. Received characters arrive through a push strobe and are read back with carrier flags attached.

The bus side is a synchronous register port with four word addresses. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read strobe.

Top module: `tx_line_steer`

## Requirements
- R1: After reset, the transmit control/status register reads 0x0001_0080: enable mask 0001 in bits 19:16, ID 0 in bits 11:8, done in bit 7, interrupt enable off in bit 6. All four lines are ready, and the receive control/status register reads 0.
- R2: A transmit control/status write with bit 15 set re-evaluates the ID. The block picks the first line that is both enabled and ready, checking line 3, then line 2, line 1 and line 0. If no line qualifies, the ID is 0xF.
- R3: A transmit control/status write with bit 15 clear changes only the enable mask (bits 19:16) and the interrupt enable (bit 6). The ID and the done flag keep their values.
- R4: Every re-evaluation sets done. After a re-evaluation, the transmit interrupt output equals the interrupt enable.
- R5: A write to the transmit data register (address 3) while the ID is 0 to 3 does four things: it pulses that line's valid output for one cycle, it latches bits 15:0 on that line's data output, it marks the line busy, and it clears done and the transmit interrupt.
- R6: A transmit data write while the ID is 0xF is ignored. No valid pulse is produced, and done and the interrupt keep their values.
- R7: A completion pulse on a line makes that line ready and re-evaluates the ID in the same cycle, with the effects of R2 and R4.
- R8: In either control/status register, writing bit 6 as 0 clears that side's interrupt. Writing it as 1 while done is set raises the interrupt.
- R9: A receive push while receive done is clear loads the character, sets receive done and raises the receive interrupt if it is enabled. A push while receive done is set is ignored.
- R10: A read of the receive data register (address 1) returns the character in bits 7:0 with carrier flags 1101 (lines 3, 2 and 0) in bits 19:16. The read clears receive done and the receive interrupt.
- R11: Read data appears on bus_rdata one cycle after the read strobe. Unimplemented bits, and the whole transmit data address, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 receive status, 1 receive data, 2 transmit status, 3 transmit data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| rx_push | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| line_valid | output | 4 | Per-line one-cycle data strobe |
| line_data | output | 64 | Per-line 16-bit data, line i in bits 16i+15:16i |
| line_done | input | 4 | Per-line one-cycle completion pulse |

## Verification
The checker enforces several invariants on every cycle:
- the ID is always 0 to 3 or 0xF;
- at most one line strobes at a time;
- an interrupt is never pending without done and enable on its side;
- a strobe leaves done clear unless a completion arrived alongside it;
- a completion always leaves done set;
- a data write made while the ID is 0xF never produces a strobe.

Only the bench scenarios can show the priority order itself: that a busy line is skipped, that a write without bit 15 leaves the ID stale, and that a push is dropped while a character is unread. The bench compares these against its cycle-level model under both directed and random traffic.

// File: rtl/txsel_pkg.sv
package txsel_pkg;
  localparam int IE_POS     = 6;
  localparam int DONE_POS   = 7;
  localparam int ID_LSB     = 8;
  localparam int REEVAL_POS = 15;
  localparam int EN_LSB     = 16;
  localparam int IDW        = 4;
  localparam logic [IDW-1:0] ID_NONE = 4'hF;

  typedef enum logic [1:0] {
    SEL_RX_STAT = 2'd0,
    SEL_RX_DATA = 2'd1,
    SEL_TX_STAT = 2'd2,
    SEL_TX_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/txsel_prio.sv
// Fixed-priority pick: the highest-numbered line that is enabled and ready (R2).
module txsel_prio #(
  parameter int N   = 4,
  parameter int IDW = 4
) (
  input  logic [N-1:0]   en,
  input  logic [N-1:0]   rdy,
  output logic [IDW-1:0] pick
);
  always_comb begin
    pick = '1;
    for (int i = 0; i < N; i++) begin
      if (en[i] && rdy[i]) pick = IDW'(i);
    end
  end
endmodule

// File: rtl/txsel_lines.sv
// Per-line busy tracking and output data latches (R5, R7).
module txsel_lines #(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [N-1:0]  cmpl,
  output logic [N-1:0]  ready_nx,
  output logic [N-1:0]  valid,
  output logic [N*DW-1:0] data
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic          rdy_q;
    logic          vld_q;
    logic [DW-1:0] dat_q;
    logic          rdy_d;

    always_comb begin
      rdy_d = (rdy_q | cmpl[g]) & ~wr_sel[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q <= 1'b1;
        vld_q <= 1'b0;
        dat_q <= '0;
      end else begin
        rdy_q <= rdy_d;
        vld_q <= wr_sel[g];
        if (wr_sel[g]) dat_q <= wr_data;
      end
    end

    assign ready_nx[g]          = rdy_d;
    assign valid[g]             = vld_q;
    assign data[g*DW +: DW]     = dat_q;
  end
endmodule

// File: rtl/txsel_rx.sv
// Receive status/data pair (R8, R9, R10).
module txsel_rx #(
  parameter int CHW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [CHW-1:0] push_char,
  input  logic           stat_we,
  input  logic           wr_ie,
  input  logic           data_rd,
  output logic           done,
  output logic           ie,
  output logic           irq,
  output logic [CHW-1:0] chr
);
  logic           done_q, ie_q, irq_q;
  logic           done_d, ie_d, irq_d;
  logic [CHW-1:0] chr_q, chr_d;

  always_comb begin
    done_d = done_q;
    ie_d   = ie_q;
    irq_d  = irq_q;
    chr_d  = chr_q;
    if (push && !done_q) begin
      chr_d  = push_char;
      done_d = 1'b1;
      irq_d  = ie_q;
    end else if (data_rd) begin
      done_d = 1'b0;
      irq_d  = 1'b0;
    end
    if (stat_we) begin
      ie_d  = wr_ie;
      irq_d = wr_ie & done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
      chr_q  <= '0;
    end else begin
      done_q <= done_d;
      ie_q   <= ie_d;
      irq_q  <= irq_d;
      chr_q  <= chr_d;
    end
  end

  assign done = done_q;
  assign ie   = ie_q;
  assign irq  = irq_q;
  assign chr  = chr_q;
endmodule

// File: rtl/tx_line_steer.sv
module tx_line_steer
  import txsel_pkg::*;
#(
  parameter int N       = 4,
  parameter int DW      = 16,
  parameter int BUS_W   = 32,
  parameter int CHW     = 8,
  parameter logic [N-1:0] CARRIER = 4'b1101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic            tx_irq,
  output logic            rx_irq,
  input  logic            rx_push,
  input  logic [CHW-1:0]  rx_char,
  output logic [N-1:0]    line_valid,
  output logic [N*DW-1:0] line_data,
  input  logic [N-1:0]    line_done
);
  localparam logic [N-1:0] EN_RESET = N'(1);

  logic           tx_stat_we, tx_data_we, rx_stat_we, rx_data_rd;
  logic [N-1:0]   en_q, en_d;
  logic           ie_q, ie_d, done_q, done_d, irq_q, irq_d;
  logic [IDW-1:0] id_q, id_d, pick;
  logic [N-1:0]   wr_sel, ready_nx;
  logic           reeval, accept;
  logic           rx_done, rx_ie;
  logic [CHW-1:0] rx_chr;
  logic [BUS_W-1:0] rd_mux;

  assign tx_stat_we = bus_wr && (bus_addr == SEL_TX_STAT);
  assign tx_data_we = bus_wr && (bus_addr == SEL_TX_DATA);
  assign rx_stat_we = bus_wr && (bus_addr == SEL_RX_STAT);
  assign rx_data_rd = bus_rd && (bus_addr == SEL_RX_DATA);

  // Data write is steered only to a real line (R5, R6).
  assign accept = tx_data_we && (int'(id_q) < N);
  assign wr_sel = accept ? (N'(1) << id_q) : '0;
  assign reeval = (tx_stat_we && bus_wdata[REEVAL_POS]) || (|line_done);

  txsel_lines #(.N(N), .DW(DW)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel   (wr_sel),
    .wr_data  (bus_wdata[DW-1:0]),
    .cmpl     (line_done),
    .ready_nx (ready_nx),
    .valid    (line_valid),
    .data     (line_data)
  );

  txsel_prio #(.N(N), .IDW(IDW)) u_prio (
    .en   (en_d),
    .rdy  (ready_nx),
    .pick (pick)
  );

  txsel_rx #(.CHW(CHW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_char (rx_char),
    .stat_we   (rx_stat_we),
    .wr_ie     (bus_wdata[IE_POS]),
    .data_rd   (rx_data_rd),
    .done      (rx_done),
    .ie        (rx_ie),
    .irq       (rx_irq),
    .chr       (rx_chr)
  );

  // Transmit status next state (R2, R3, R4, R7, R8).
  always_comb begin
    en_d   = en_q;
    ie_d   = ie_q;
    done_d = done_q;
    irq_d  = irq_q;
    id_d   = id_q;
    if (tx_stat_we) begin
      en_d = bus_wdata[EN_LSB +: N];
      ie_d = bus_wdata[IE_POS];
    end
    if (accept) begin
      done_d = 1'b0;
      irq_d  = 1'b0;
    end
    if (reeval) begin
      id_d   = pick;
      done_d = 1'b1;
      irq_d  = ie_d;
    end
    if (tx_stat_we) irq_d = ie_d & done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= EN_RESET;
      ie_q   <= 1'b0;
      done_q <= 1'b1;
      irq_q  <= 1'b0;
      id_q   <= '0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      done_q <= done_d;
      irq_q  <= irq_d;
      id_q   <= id_d;
    end
  end

  assign tx_irq = irq_q;

  // Read mux; unimplemented bits are zero (R10, R11).
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      SEL_RX_STAT: begin
        rd_mux[DONE_POS] = rx_done;
        rd_mux[IE_POS]   = rx_ie;
      end
      SEL_RX_DATA: begin
        rd_mux[CHW-1:0]       = rx_chr;
        rd_mux[EN_LSB +: N]   = CARRIER;
      end
      SEL_TX_STAT: begin
        rd_mux[EN_LSB +: N]   = en_q;
        rd_mux[ID_LSB +: IDW] = id_q;
        rd_mux[DONE_POS]      = done_q;
        rd_mux[IE_POS]        = ie_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/txsel_chk.sv
module txsel_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [N-1:0] line_valid,
  input logic [N-1:0] line_done,
  input logic         tx_irq,
  input logic         rx_irq,
  input logic         tx_done,
  input logic         tx_ie,
  input logic [3:0]   tx_id,
  input logic         rx_done,
  input logic         rx_ie
);
  p_id_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_id < 4'(N)) || (tx_id == 4'hF));

  p_irq_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tx_done && tx_ie));

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_valid));

  p_strobe_clears_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|line_valid) && !$past(|line_done)) |-> !tx_done);

  p_no_strobe_when_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && tx_id == 4'hF) |=> (line_valid == '0));

  p_cmpl_sets_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_done) |=> tx_done);

  p_rx_irq_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_done && rx_ie));
endmodule

bind tx_line_steer txsel_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .line_valid (line_valid),
  .line_done  (line_done),
  .tx_irq     (tx_irq),
  .rx_irq     (rx_irq),
  .tx_done    (done_q),
  .tx_ie      (ie_q),
  .tx_id      (id_q),
  .rx_done    (rx_done),
  .rx_ie      (rx_ie)
);

// File: tb/tb_tx_line_steer.sv
`timescale 1ns/1ps
module tb_tx_line_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_irq, rx_irq;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_char = '0;
  logic [3:0]  line_valid;
  logic [63:0] line_data;
  logic [3:0]  line_done = '0;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  tx_line_steer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_push(rx_push), .rx_char(rx_char),
    .line_valid(line_valid), .line_data(line_data), .line_done(line_done)
  );

  // ---------------- reference model ----------------
  bit [3:0]  m_en, m_ready, m_id, m_valid;
  bit        m_ie, m_done, m_irq;
  bit        m_rxdone, m_rxie, m_rxirq;
  bit [7:0]  m_rxchar;
  bit [15:0] m_ldata [4];
  bit [31:0] m_rd;

  function automatic bit [3:0] choose(bit [3:0] en, bit [3:0] rdy);
    for (int i = 3; i >= 0; i--) if (en[i] && rdy[i]) return 4'(i);
    return 4'hF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 4'b0001; m_ready = 4'hF; m_id = 0; m_valid = 0;
      m_ie = 0; m_done = 1; m_irq = 0;
      m_rxdone = 0; m_rxie = 0; m_rxirq = 0; m_rxchar = 0; m_rd = 0;
      foreach (m_ldata[i]) m_ldata[i] = 0;
    end else begin
      bit [3:0] nrdy, nen; bit nie, ndone, nirq, again, rdn, rirq;
      if (bus_rd) begin
        case (bus_addr)
          2'd0: m_rd = {24'h0, m_rxdone, m_rxie, 6'h0};
          2'd1: m_rd = {12'h0, 4'hD, 8'h0, m_rxchar};
          2'd2: m_rd = {12'h0, m_en, 4'h0, m_id, m_done, m_ie, 6'h0};
          default: m_rd = 0;
        endcase
      end
      nrdy = m_ready | line_done; nen = m_en; nie = m_ie;
      ndone = m_done; nirq = m_irq; again = |line_done; m_valid = 0;
      if (bus_wr && bus_addr == 2) begin
        nen = bus_wdata[19:16]; nie = bus_wdata[6];
        if (bus_wdata[15]) again = 1;
      end
      if (bus_wr && bus_addr == 3 && m_id < 4) begin
        m_valid[m_id] = 1; m_ldata[m_id] = bus_wdata[15:0];
        nrdy[m_id] = 0; ndone = 0; nirq = 0;
      end
      if (again) begin m_id = choose(nen, nrdy); ndone = 1; nirq = nie; end
      if (bus_wr && bus_addr == 2) nirq = nie & ndone;
      m_en = nen; m_ie = nie; m_done = ndone; m_irq = nirq; m_ready = nrdy;
      rdn = m_rxdone; rirq = m_rxirq;
      if (rx_push && !m_rxdone) begin m_rxchar = rx_char; rdn = 1; rirq = m_rxie; end
      else if (bus_rd && bus_addr == 1) begin rdn = 0; rirq = 0; end
      if (bus_wr && bus_addr == 0) begin m_rxie = bus_wdata[6]; rirq = bus_wdata[6] & rdn; end
      m_rxdone = rdn; m_rxirq = rirq;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R11 rdata", bus_rdata, m_rd);
    chk("R4 tx_irq", 32'(tx_irq), 32'(m_irq));
    chk("R9 rx_irq", 32'(rx_irq), 32'(m_rxirq));
    chk("R5 line_valid", 32'(line_valid), 32'(m_valid));
    for (int i = 0; i < 4; i++) chk("R5 line_data", 32'(line_data[16*i +: 16]), 32'(m_ldata[i]));
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(bit [1:0] a, bit [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(bit [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask
  task automatic cmpl(bit [3:0] m);
    @(negedge clk); line_done = m;
    @(negedge clk); line_done = 0;
  endtask
  task automatic push(bit [7:0] c);
    @(negedge clk); rx_push = 1; rx_char = c;
    @(negedge clk); rx_push = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2, v); chk("R1", v, 32'h0001_0080);
    rd(0, v); chk("R1", v, 32'h0);
    // R2 / R4: enable all, re-evaluate, interrupt enable
    wr(2, 32'h000F_8040); chk("R4", 32'(tx_irq), 1);
    rd(2, v); chk("R2", v, 32'h000F_03C0);
    // R5 data goes to line 3
    wr(3, 32'hABCD_1234);
    chk("R5", 32'(line_valid), 32'h8); chk("R5", 32'(line_data[63:48]), 32'h1234);
    chk("R5", 32'(tx_irq), 0);
    rd(2, v); chk("R5", v, 32'h000F_0340);
    // R2 busy line 3 skipped
    wr(2, 32'h000F_8040); rd(2, v); chk("R2", v, 32'h000F_02C0);
    // R3 no re-evaluation
    wr(2, 32'h0004_0040); rd(2, v); chk("R3", v, 32'h0004_02C0);
    // R2 no line qualifies -> 0xF
    wr(3, 32'h0000_5555); chk("R5", 32'(line_data[47:32]), 32'h5555);
    wr(2, 32'h0004_8040); rd(2, v); chk("R2", v, 32'h0004_0FC0);
    // R6 data write ignored while ID is 0xF
    wr(3, 32'h0000_9999); chk("R6", 32'(line_valid), 0);
    rd(2, v); chk("R6", v, 32'h0004_0FC0); chk("R6", 32'(tx_irq), 1);
    // R7 completion re-evaluates
    cmpl(4'b0100); rd(2, v); chk("R7", v, 32'h0004_02C0);
    cmpl(4'b1000);
    // R8 interrupt enable writes
    wr(2, 32'h000F_8000); chk("R8", 32'(tx_irq), 0);
    wr(2, 32'h000F_0040); chk("R8", 32'(tx_irq), 1);
    rd(2, v); chk("R7", v, 32'h000F_03C0);
    // R9 receive push, R8 receive enable
    push(8'h41); rd(0, v); chk("R9", v, 32'h80);
    wr(0, 32'h40); chk("R8", 32'(rx_irq), 1);
    push(8'h42);
    rd(1, v); chk("R10", v, 32'h000D_0041); chk("R10", 32'(rx_irq), 0);
    rd(0, v); chk("R10", v, 32'h40);
    push(8'h43); chk("R9", 32'(rx_irq), 1);
    rd(1, v); chk("R9", v, 32'h000D_0043);
    rd(3, v); chk("R11", v, 32'h0);
    // random traffic against the model
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      bus_wr = 0; bus_rd = 0;
      case ($urandom_range(0, 3))
        0: begin bus_wr = 1; bus_addr = 2'($urandom_range(0, 3));
                 bus_wdata = $urandom; end
        1: begin bus_rd = 1; bus_addr = 2'($urandom_range(0, 3)); end
        default: ;
      endcase
      line_done = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
      rx_push = ($urandom_range(0, 6) == 0); rx_char = 8'($urandom);
    end
    @(negedge clk); bus_wr = 0; bus_rd = 0; line_done = 0; rx_push = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule